// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This block is a single-cycle registered datapath for a family of signed DSP multiply operations on 32-bit words. A 4-bit operation code selects one of several modes: a 16x16 multiply whose halfwords are picked per operand, the same multiply with a 32-bit accumulate, a word-by-halfword multiply that keeps product bits 47:16 (with or without accumulate), a dual halfword multiply that adds or subtracts its two products before accumulating, and 32x32 multiplies that return either the low word or the full 64-bit product.

Alongside the operands the block takes the current 32-bit condition-flag word and returns it updated. Accumulating modes never saturate. When the wide signed sum leaves the 32-bit range they set a sticky overflow bit. The plain word multiplies can optionally load a sign bit and a zero bit. All results and the flag word are registered, so they appear one clock after the inputs are presented.

Top module: `shmac_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_lo`, `res_hi` and `flags_out` become zero. Otherwise the outputs after each edge reflect the inputs sampled at that edge.
- R2: Op code 1 multiplies two sign-extended halfwords. `sel_a_hi`/`sel_b_hi` = 1 picks bits 31:16 of `opnd_a`/`opnd_b`, and 0 picks bits 15:0. `res_lo` is the low word of the product, and `flags_out` equals `flags_in`.
- R3: Op code 2 adds the sign-extended `opnd_c` to the op 1 product. `res_lo` is the low 32 bits of the sum. Bit 27 of the flags is set when bits 32 and 31 of the 64-bit signed sum differ.
- R4: Op code 3 multiplies the signed 32-bit `opnd_a` by the halfword of `opnd_b` selected by `sel_b_hi`. It shifts the product right arithmetically by 16 and returns its low 32 bits. `flags_out` equals `flags_in`.
- R5: Op code 4 works like op 3, but first adds `opnd_c` shifted left by 16 to the product. Bit 27 is set when bits 32 and 31 of the shifted sum differ.
- R6: Op code 5 returns hi(a)*hi(b) + lo(a)*lo(b) + `opnd_c`, with overflow to bit 27 as in R3. The halfword selects are ignored.
- R7: Op code 6 returns lo(a)*lo(b) - hi(a)*hi(b) + `opnd_c`, with overflow to bit 27 as in R3.
- R8: Bit 27 of the flags is sticky: no operation clears it. Results that overflow wrap and are not saturated.
- R9: Op code 7 returns the low word of the signed 32x32 product. With `set_flags` = 1, bit 31 takes the result sign, bit 30 is 1 when the result is zero, and bits 29:0 are kept. With `set_flags` = 0, the flags pass through unchanged.
- R10: Op code 8 returns the signed 64-bit product, high word on `res_hi` and low word on `res_lo`. With `set_flags` = 1, bit 31 takes product bit 63, bit 30 is 1 when all 64 bits are zero, and bits 29:0 are kept.
- R11: Op codes 0 and 9 to 15 give zero results with the flags unchanged. `res_hi` is zero for every op except 8. `set_flags` has no effect except on ops 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation select |
| sel_a_hi | input | 1 | Take upper halfword of `opnd_a` (op 1, 2) |
| sel_b_hi | input | 1 | Take upper halfword of `opnd_b` (op 1 to 4) |
| set_flags | input | 1 | Load sign/zero bits (op 7, 8) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| opnd_c | input | 32 | Accumulator operand |
| flags_in | input | 32 | Current flag word |
| res_lo | output | 32 | Result, low word |
| res_hi | output | 32 | Result, high word (op 8 only) |
| flags_out | output | 32 | Updated flag word |

## Verification
The block holds no state beyond its output registers. A faulty halfword select, sign extension or shift therefore shows on `res_lo` one cycle after the offending operand pattern and corrupts no later results. A fault in the overflow compare or in the sticky-bit merge shows the same cycle as a wrong bit 27 in `flags_out`. Mode-dependent faults only appear for the op code and operand sign combination that exercises them. For that reason the sweep covers every code, both halfword selects, both flag-setting values and operands at the halfword extremes.

// File: rtl/shmac_pkg.sv
package shmac_pkg;
  localparam int FLAG_W   = 32;
  localparam int FLAG_N   = 31;
  localparam int FLAG_Z   = 30;
  localparam int FLAG_OVF = 27;

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_HMUL     = 4'd1,
    OP_HMAC     = 4'd2,
    OP_WHMUL    = 4'd3,
    OP_WHMAC    = 4'd4,
    OP_DUAL_ADD = 4'd5,
    OP_DUAL_SUB = 4'd6,
    OP_WMUL     = 4'd7,
    OP_LMUL     = 4'd8
  } shmac_op_e;

  typedef enum logic [1:0] {
    FM_KEEP = 2'd0,
    FM_WORD = 2'd1,
    FM_LONG = 2'd2
  } flag_mode_e;
endpackage

// File: rtl/shmac_half_split.sv
module shmac_half_split #(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int WIDE_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0]        word_in,
  input  logic                     pick_hi,
  output logic signed [WIDE_W-1:0] ext_sel,
  output logic signed [WIDE_W-1:0] ext_hi,
  output logic signed [WIDE_W-1:0] ext_lo,
  output logic signed [WIDE_W-1:0] ext_word
);
  logic [HALF_W-1:0] half_hi, half_lo;

  always_comb begin
    half_hi  = word_in[DATA_W-1:HALF_W];
    half_lo  = word_in[HALF_W-1:0];
    ext_hi   = {{(WIDE_W-HALF_W){half_hi[HALF_W-1]}}, half_hi};
    ext_lo   = {{(WIDE_W-HALF_W){half_lo[HALF_W-1]}}, half_lo};
    ext_sel  = pick_hi ? ext_hi : ext_lo;
    ext_word = {{(WIDE_W-DATA_W){word_in[DATA_W-1]}}, word_in};
  end
endmodule

// File: rtl/shmac_core.sv
module shmac_core
  import shmac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int WIDE_W = 2 * DATA_W
) (
  input  logic [3:0]               op_code,
  input  logic                     sel_a_hi,
  input  logic                     sel_b_hi,
  input  logic [DATA_W-1:0]        opnd_a,
  input  logic [DATA_W-1:0]        opnd_b,
  input  logic [DATA_W-1:0]        opnd_c,
  output logic signed [WIDE_W-1:0] wide_res,
  output logic                     ovf_check,
  output flag_mode_e               flag_mode
);
  localparam int NOPS = 2;

  logic [DATA_W-1:0]        words [NOPS];
  logic                     picks [NOPS];
  logic signed [WIDE_W-1:0] e_sel [NOPS];
  logic signed [WIDE_W-1:0] e_hi  [NOPS];
  logic signed [WIDE_W-1:0] e_lo  [NOPS];
  logic signed [WIDE_W-1:0] e_wd  [NOPS];

  assign words[0] = opnd_a;
  assign words[1] = opnd_b;
  assign picks[0] = sel_a_hi;
  assign picks[1] = sel_b_hi;

  for (genvar g = 0; g < NOPS; g++) begin : g_split
    shmac_half_split #(.DATA_W(DATA_W)) split_i (
      .word_in (words[g]),
      .pick_hi (picks[g]),
      .ext_sel (e_sel[g]),
      .ext_hi  (e_hi[g]),
      .ext_lo  (e_lo[g]),
      .ext_word(e_wd[g])
    );
  end

  logic signed [WIDE_W-1:0] acc_ext, p_hh, p_tt, p_bb, p_wh, p_ww;

  always_comb begin
    acc_ext = {{(WIDE_W-DATA_W){opnd_c[DATA_W-1]}}, opnd_c};
    p_hh    = e_sel[0] * e_sel[1];
    p_tt    = e_hi[0]  * e_hi[1];
    p_bb    = e_lo[0]  * e_lo[1];
    p_wh    = e_wd[0]  * e_sel[1];
    p_ww    = e_wd[0]  * e_wd[1];
  end

  always_comb begin
    wide_res  = '0;
    ovf_check = 1'b0;
    flag_mode = FM_KEEP;
    case (op_code)
      OP_HMUL:     wide_res = p_hh;
      OP_HMAC: begin
        wide_res  = p_hh + acc_ext;
        ovf_check = 1'b1;
      end
      OP_WHMUL:    wide_res = p_wh >>> HALF_W;
      OP_WHMAC: begin
        wide_res  = (p_wh + (acc_ext <<< HALF_W)) >>> HALF_W;
        ovf_check = 1'b1;
      end
      OP_DUAL_ADD: begin
        wide_res  = p_tt + p_bb + acc_ext;
        ovf_check = 1'b1;
      end
      OP_DUAL_SUB: begin
        wide_res  = p_bb - p_tt + acc_ext;
        ovf_check = 1'b1;
      end
      OP_WMUL: begin
        wide_res  = p_ww;
        flag_mode = FM_WORD;
      end
      OP_LMUL: begin
        wide_res  = p_ww;
        flag_mode = FM_LONG;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shmac_flag_update.sv
module shmac_flag_update
  import shmac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int WIDE_W = 2 * DATA_W
) (
  input  logic [FLAG_W-1:0]        flags_in,
  input  logic signed [WIDE_W-1:0] wide_res,
  input  logic                     ovf_check,
  input  flag_mode_e               flag_mode,
  input  logic                     set_flags,
  output logic [FLAG_W-1:0]        flags_next
);
  logic out_of_range;

  always_comb begin
    out_of_range = wide_res[DATA_W] ^ wide_res[DATA_W-1];
    flags_next   = flags_in;
    if (ovf_check && out_of_range) flags_next[FLAG_OVF] = 1'b1;
    if (set_flags) begin
      case (flag_mode)
        FM_WORD: begin
          flags_next[FLAG_N] = wide_res[DATA_W-1];
          flags_next[FLAG_Z] = (wide_res[DATA_W-1:0] == '0);
        end
        FM_LONG: begin
          flags_next[FLAG_N] = wide_res[WIDE_W-1];
          flags_next[FLAG_Z] = (wide_res == '0);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shmac_unit.sv
module shmac_unit
  import shmac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int WIDE_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_code,
  input  logic              sel_a_hi,
  input  logic              sel_b_hi,
  input  logic              set_flags,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] opnd_c,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi,
  output logic [FLAG_W-1:0] flags_out
);
  logic signed [WIDE_W-1:0] wide_res;
  logic                     ovf_check;
  flag_mode_e               flag_mode;
  logic [FLAG_W-1:0]        flags_next;

  shmac_core #(.DATA_W(DATA_W)) core_i (
    .op_code  (op_code),
    .sel_a_hi (sel_a_hi),
    .sel_b_hi (sel_b_hi),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .opnd_c   (opnd_c),
    .wide_res (wide_res),
    .ovf_check(ovf_check),
    .flag_mode(flag_mode)
  );

  shmac_flag_update #(.DATA_W(DATA_W)) flag_i (
    .flags_in  (flags_in),
    .wide_res  (wide_res),
    .ovf_check (ovf_check),
    .flag_mode (flag_mode),
    .set_flags (set_flags),
    .flags_next(flags_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_lo    <= '0;
      res_hi    <= '0;
      flags_out <= '0;
    end else begin
      res_lo    <= wide_res[DATA_W-1:0];
      res_hi    <= (flag_mode == FM_LONG) ? wide_res[WIDE_W-1:DATA_W] : '0;
      flags_out <= flags_next;
    end
  end
endmodule

// File: rtl/shmac_unit_chk.sv
module shmac_unit_chk
  import shmac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_code,
  input logic [FLAG_W-1:0] flags_in,
  input logic [DATA_W-1:0] res_lo,
  input logic [DATA_W-1:0] res_hi,
  input logic [FLAG_W-1:0] flags_out
);
  assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flags_in[FLAG_OVF])) |-> flags_out[FLAG_OVF]);

  assert_low_flags_kept_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flags_out[FLAG_OVF-1:0] == $past(flags_in[FLAG_OVF-1:0])));

  assert_unused_op_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_code) >= 4'd9 || $past(op_code) == 4'd0)) |->
    (res_lo == '0 && res_hi == '0 && flags_out == $past(flags_in)));

  assert_hi_word_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) != 4'd8) |-> (res_hi == '0));

  assert_plain_mul_keeps_flags_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_code) == 4'd1 || $past(op_code) == 4'd3)) |->
    (flags_out == $past(flags_in)));
endmodule

bind shmac_unit shmac_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_code  (op_code),
  .flags_in (flags_in),
  .res_lo   (res_lo),
  .res_hi   (res_hi),
  .flags_out(flags_out)
);

// File: tb/shmac_unit_tb_top.sv
module shmac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code = '0;
  logic        sel_a_hi = 1'b0, sel_b_hi = 1'b0, set_flags = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0, flags_in = '0;
  logic [31:0] res_lo, res_hi, flags_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shmac_unit dut_i (
    .clk(clk), .rst(rst), .op_code(op_code), .sel_a_hi(sel_a_hi),
    .sel_b_hi(sel_b_hi), .set_flags(set_flags), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .opnd_c(opnd_c), .flags_in(flags_in),
    .res_lo(res_lo), .res_hi(res_hi), .flags_out(flags_out)
  );

  function automatic string req_tag(input logic [3:0] op);
    case (op)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R9";
      4'd8: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic void model(input logic [3:0] op, input logic ah, input logic bh,
                                input logic sf, input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] c, input logic [31:0] f,
                                output logic [31:0] lo, output logic [31:0] hi,
                                output logic [31:0] fo);
    longint sa, sb, sc, ha, hb, ta, tb_, ba, bb, r;
    bit acc;
    sa = $signed(a); sb = $signed(b); sc = $signed(c);
    ta = $signed(a[31:16]); ba = $signed(a[15:0]);
    tb_ = $signed(b[31:16]); bb = $signed(b[15:0]);
    ha = ah ? ta : ba;
    hb = bh ? tb_ : bb;
    acc = 1'b0; r = 0; fo = f; hi = '0;
    case (op)
      4'd1: r = ha * hb;
      4'd2: begin r = ha * hb + sc; acc = 1'b1; end
      4'd3: r = (sa * hb) >>> 16;
      4'd4: begin r = (sa * hb + sc * 65536) >>> 16; acc = 1'b1; end
      4'd5: begin r = ta * tb_ + ba * bb + sc; acc = 1'b1; end
      4'd6: begin r = ba * bb - ta * tb_ + sc; acc = 1'b1; end
      4'd7: begin
        r = sa * sb;
        if (sf) begin fo[31] = r[31]; fo[30] = (r[31:0] == 0); end
      end
      4'd8: begin
        r = sa * sb;
        hi = r[63:32];
        if (sf) begin fo[31] = r[63]; fo[30] = (r == 0); end
      end
      default: r = 0;
    endcase
    if (acc && (r[32] != r[31])) fo[27] = 1'b1;
    lo = r[31:0];
  endfunction

  task automatic compare(input string tag, input logic [31:0] lo, input logic [31:0] hi,
                         input logic [31:0] fo);
    checks++;
    if (res_lo !== lo || res_hi !== hi || flags_out !== fo) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h c=%h: got lo=%h hi=%h fl=%h expected lo=%h hi=%h fl=%h",
               tag, op_code, opnd_a, opnd_b, opnd_c, res_lo, res_hi, flags_out, lo, hi, fo);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic ah, input logic bh, input logic sf,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input logic [31:0] f, input string tag);
    logic [31:0] elo, ehi, efo;
    @(negedge clk);
    op_code = op; sel_a_hi = ah; sel_b_hi = bh; set_flags = sf;
    opnd_a = a; opnd_b = b; opnd_c = c; flags_in = f;
    model(op, ah, bh, sf, a, b, c, f, elo, ehi, efo);
    @(posedge clk);
    @(negedge clk);
    compare(tag, elo, ehi, efo);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  logic [31:0] vals [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_8000, 32'h8000_7FFF,
                            32'hFFFF_FFFF, 32'h8000_8000, 32'h7FFF_7FFF, 32'h1234_ABCD};
  logic [31:0] accs [4] = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_0001};
  logic [31:0] flgs [2] = '{32'h1234_5670, 32'hF800_00A5};

  initial begin
    op_code = 4'd8; opnd_a = 32'h7FFF_FFFF; opnd_b = 32'h7FFF_FFFF; flags_in = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset", '0, '0, '0);
    rst = 1'b0;

    for (int op = 0; op < 16; op++)
      for (int s = 0; s < 8; s++)
        for (int ia = 0; ia < 8; ia++)
          for (int ib = 0; ib < 8; ib++)
            for (int ic = 0; ic < 4; ic++)
              for (int iflg = 0; iflg < 2; iflg++)
                apply(op[3:0], s[2], s[1], s[0], vals[ia], vals[ib], accs[ic], flgs[iflg],
                      req_tag(op[3:0]));

    // R6/R8: dual sum of two minimum-halfword squares wraps and sets sticky bit 27
    apply(4'd5, 0, 0, 0, 32'h8000_8000, 32'h8000_8000, 32'h0, 32'h0, "R8 dual wrap");
    if (res_lo !== 32'h8000_0000 || flags_out !== 32'h0800_0000) begin
      errors++;
      $display("FAIL R8 lo=%h fl=%h expected lo=80000000 fl=08000000", res_lo, flags_out);
    end
    checks++;
    // R8: sticky bit survives a non-overflowing accumulate
    apply(4'd2, 0, 0, 0, 32'h1, 32'h1, 32'h1, 32'h0800_0000, "R8 sticky");
    if (flags_out !== 32'h0800_0000 || res_lo !== 32'h2) begin
      errors++;
      $display("FAIL R8 lo=%h fl=%h expected lo=00000002 fl=08000000", res_lo, flags_out);
    end
    checks++;
    // R10: largest negative squared, and zero product with flag setting
    apply(4'd8, 0, 0, 1, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, "R10 min sq");
    if (res_hi !== 32'h4000_0000 || res_lo !== 32'h0 || flags_out !== 32'h0) begin
      errors++;
      $display("FAIL R10 hi=%h lo=%h fl=%h expected hi=40000000 lo=00000000 fl=00000000",
               res_hi, res_lo, flags_out);
    end
    checks++;
    apply(4'd8, 0, 0, 1, 32'h0, 32'h1234_5678, 32'h0, 32'h8000_0001, "R10 zero");
    // R9: word product negative sets sign, clears zero
    apply(4'd7, 0, 0, 1, 32'hFFFF_FFFF, 32'h2, 32'h0, 32'h4000_0000, "R9 sign");
    // R11: set_flags ignored on halfword multiply
    apply(4'd1, 1, 0, 1, 32'h0002_0000, 32'h0000_0003, 32'h0, 32'h0000_0000, "R11 sf ignored");
    // R1: reset mid-run clears registered outputs
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare("R1 mid reset", '0, '0, '0);
    rst = 1'b0;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: got running expected finished");
    finish_run();
  end
endmodule